// File: doc/BRIEF.md
# Load/Store Multiple Transfer Sequencer

This block turns one block-transfer command into a stream of single-word memory requests between a 16-entry register file and memory. The command gives a base address, a 16-bit register mask, a direction (load or store), one of four addressing modes and a writeback flag. The block issues one request per cycle. Each request carries a word address, the register index and the direction. Registers always go out in ascending index order, and the lowest-numbered register always sits at the lowest address. When the walk is over, the block pulses `done`. If writeback was asked for, it also presents the updated base with a write enable. A full-descending push is decrement-before with writeback. The matching pop is increment-after with writeback.

The controller has three states, `ST_IDLE`, `ST_XFER` and `ST_FIN`, with four transitions:
- idle-to-transfer: a start arrives with a non-empty mask.
- idle-to-finish: a start arrives with an empty mask.
- transfer-to-finish: the last set mask bit has just been issued.
- finish-to-idle: always, after one cycle.

In every other case the transfer state stays in place. It clears one mask bit and adds one word to the address each cycle.

Top module: `lsm_seq`

## Requirements
- R1: One request (`req_valid`=1) is issued per cycle for each set bit of `reg_mask`. `req_reg` gives the bit index, and the indices come out strictly ascending. The first request appears in the cycle after the clock edge that samples `start`.
- R2: Successive requests of one transfer have addresses that each rise by 4.
- R3: Mode encoding is 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before. With n set bits in the mask, the first (lowest) address is:
  - base for mode 0;
  - base+4 for mode 1.
- R4: With the same encoding, the first (lowest) address is:
  - base−4n+4 for mode 2;
  - base−4n for mode 3.
- R5: `done` is a one-cycle pulse in the cycle after the last request, with `req_valid` low. `busy` is high from the cycle after start up to and including the `done` cycle, and low afterwards.
- R6: When `wback`=1 and there is no error, `wb_en` is high in the `done` cycle, with `wb_value` = base+4n for modes 0 and 1 and base−4n for modes 2 and 3. When `wback`=0, `wb_en` stays low.
- R7: An all-zero mask produces no request, and `done` comes in the cycle after start.
- R8: `start` is ignored while `busy` is high. The transfer in flight continues with its original mask, address and direction.
- R9: `err` is high in the `done` cycle when `wback`=1 and `reg_mask[base_idx]`=1. In that case `wb_en` stays low.
- R10: `req_write` is the inverse of the `is_load` value sampled with start, on every request.
- R11: After reset the block is idle, and `busy`, `req_valid`, `done`, `wb_en` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled when idle |
| base_addr | input | 32 | Base register value |
| base_idx | input | 4 | Index of the base register |
| reg_mask | input | 16 | Registers to transfer |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| mode | input | 2 | Addressing mode (see R3, R4) |
| wback | input | 1 | Write the final address back to the base |
| busy | output | 1 | Command in progress |
| req_valid | output | 1 | Memory request this cycle |
| req_addr | output | 32 | Word address of the request |
| req_reg | output | 4 | Register index of the request |
| req_write | output | 1 | Request is a memory write |
| done | output | 1 | Transfer complete pulse |
| wb_en | output | 1 | Base writeback enable |
| wb_value | output | 32 | Updated base value |
| err | output | 1 | Base register in mask with writeback |

## Verification
The bench covers every combination of mode, direction and writeback, over single-bit, full, empty and pseudo-random masks. It computes every address from the population count.

- Empty and single-bit masks expose off-by-one errors. A design that miscounted would issue a stray request or finish one cycle late.
- The decrement modes expose a design that walks downward from base. Such a design would put high registers at low addresses or start one word off.
- A start pulse is injected mid-transfer. A design that re-latched it would switch masks partway through.
- Base-in-mask cases with writeback check that the error shows and that the writeback is withheld.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
    parameter int NBITS = 16,
    localparam int CNT_W = $clog2(NBITS + 1)
) (
    input  logic [NBITS-1:0] bits,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] psum [0:NBITS];

    assign psum[0] = '0;
    for (genvar g = 0; g < NBITS; g++) begin : g_acc
        assign psum[g+1] = psum[g] + CNT_W'(bits[g]);
    end
    assign count = psum[NBITS];
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int NBITS = 16,
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic [NBITS-1:0] bits,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [NBITS-1:0] onehot
);
    always_comb begin
        any    = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = NBITS - 1; i >= 0; i--) begin
            if (bits[i]) begin
                any    = 1'b1;
                idx    = IDX_W'(i);
                onehot = NBITS'(1) << i;
            end
        end
    end
endmodule

// File: rtl/lsm_addrgen.sv
module lsm_addrgen
    import lsm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 5,
    parameter int WORD_BYTES = 4,
    localparam int BYTE_SH   = $clog2(WORD_BYTES)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  addr_mode_t        mode,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] final_addr
);
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] word;

    assign span = ADDR_W'(count) << BYTE_SH;
    assign word = ADDR_W'(WORD_BYTES);

    always_comb begin
        unique case (mode)
            AM_INC_AFTER: begin
                first_addr = base;
                final_addr = base + span;
            end
            AM_INC_BEFORE: begin
                first_addr = base + word;
                final_addr = base + span;
            end
            AM_DEC_AFTER: begin
                first_addr = base - span + word;
                final_addr = base - span;
            end
            AM_DEC_BEFORE: begin
                first_addr = base - span;
                final_addr = base - span;
            end
        endcase
    end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREGS      = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREGS),
    localparam int CNT_W     = $clog2(NREGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [NREGS-1:0]  reg_mask,
    input  logic              is_load,
    input  logic [1:0]        mode,
    input  logic              wback,
    output logic              busy,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [IDX_W-1:0]  req_reg,
    output logic              req_write,
    output logic              done,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_value,
    output logic              err
);
    seq_state_t state_q, state_d;

    logic [NREGS-1:0]  mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] final_q;
    logic              write_q;
    logic              wb_q;
    logic              err_q;

    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] final_addr;
    logic              low_any;
    logic [IDX_W-1:0]  low_idx;
    logic [NREGS-1:0]  low_oh;
    logic [NREGS-1:0]  mask_rest;
    logic              hazard;
    logic              accept;

    lsm_popcnt #(.NBITS(NREGS)) u_cnt (
        .bits  (reg_mask),
        .count (cnt)
    );

    lsm_addrgen #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_agen (
        .base       (base_addr),
        .count      (cnt),
        .mode       (addr_mode_t'(mode)),
        .first_addr (first_addr),
        .final_addr (final_addr)
    );

    lsm_lowbit #(.NBITS(NREGS)) u_low (
        .bits   (mask_q),
        .any    (low_any),
        .idx    (low_idx),
        .onehot (low_oh)
    );

    assign mask_rest = mask_q & ~low_oh;
    assign hazard    = wback & reg_mask[base_idx];
    assign accept    = (state_q == ST_IDLE) && start;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (reg_mask == '0) ? ST_FIN : ST_XFER;
            ST_XFER: if (mask_rest == '0) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Command and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            addr_q  <= '0;
            final_q <= '0;
            write_q <= 1'b0;
            wb_q    <= 1'b0;
            err_q   <= 1'b0;
        end else if (accept) begin
            mask_q  <= reg_mask;
            addr_q  <= first_addr;
            final_q <= final_addr;
            write_q <= ~is_load;
            wb_q    <= wback & ~hazard;
            err_q   <= hazard;
        end else if (state_q == ST_XFER) begin
            mask_q  <= mask_rest;
            addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
        end
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        req_valid = 1'b0;
        req_addr  = addr_q;
        req_reg   = low_idx;
        req_write = write_q;
        done      = 1'b0;
        wb_en     = 1'b0;
        wb_value  = final_q;
        err       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                busy      = 1'b1;
                req_valid = low_any;
            end
            ST_FIN: begin
                busy  = 1'b1;
                done  = 1'b1;
                wb_en = wb_q;
                err   = err_q;
            end
            default: ;
        endcase
    end

    p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid) |-> req_reg > $past(req_reg));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid) |-> req_addr == $past(req_addr) + ADDR_W'(WORD_BYTES));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_no_req_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    p_wb_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    p_err_blocks_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !wb_en);

    p_dir_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid) |-> $stable(req_write));
endmodule

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [3:0]  base_idx = '0;
    logic [15:0] reg_mask = '0;
    logic        is_load = 1'b0;
    logic [1:0]  mode = '0;
    logic        wback = 1'b0;
    logic        busy, req_valid, req_write, done, wb_en, err;
    logic [31:0] req_addr, wb_value;
    logic [3:0]  req_reg;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lsm_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .base_idx(base_idx), .reg_mask(reg_mask), .is_load(is_load),
        .mode(mode), .wback(wback), .busy(busy), .req_valid(req_valid),
        .req_addr(req_addr), .req_reg(req_reg), .req_write(req_write),
        .done(done), .wb_en(wb_en), .wb_value(wb_value), .err(err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] md, input logic [15:0] msk, input bit ld,
                       input bit wb, input logic [31:0] base, input logic [3:0] bidx,
                       input bit inject);
        int n;
        logic [31:0] low, fin, a;
        bit hz;
        n = $countones(msk);
        case (md)
            2'd0: low = base;
            2'd1: low = base + 32'd4;
            2'd2: low = base - 32'(4 * n) + 32'd4;
            default: low = base - 32'(4 * n);
        endcase
        fin = md[1] ? base - 32'(4 * n) : base + 32'(4 * n);
        hz = wb && msk[bidx];
        @(negedge clk);
        start = 1'b1; mode = md; reg_mask = msk; is_load = ld; wback = wb;
        base_addr = base; base_idx = bidx;
        @(negedge clk);
        start = 1'b0;
        a = low;
        for (int i = 0; i < 16; i++) begin
            if (msk[i]) begin
                check(req_valid === 1'b1, "R1 valid", 32'(req_valid), 32'd1);
                check(req_reg === 4'(i), "R1 reg", 32'(req_reg), 32'(i));
                check(req_addr === a, (md[1] ? "R4 addr" : (a == low ? "R3 addr" : "R2 addr")), req_addr, a);
                check(req_write === !ld, "R10 dir", 32'(req_write), 32'(!ld));
                check(busy === 1'b1, "R5 busy", 32'(busy), 32'd1);
                a = a + 32'd4;
                if (inject && a == low + 32'd4) begin
                    // R8: new command presented while busy
                    start = 1'b1; reg_mask = ~msk; is_load = !ld; mode = ~md;
                    base_addr = base ^ 32'hFFFF_0000; wback = !wb;
                end
                @(negedge clk);
                start = 1'b0;
            end
        end
        if (n == 0) check(req_valid === 1'b0, "R7 noreq", 32'(req_valid), 32'd0);
        check(done === 1'b1, (n == 0) ? "R7 done" : (inject ? "R8 done" : "R5 done"), 32'(done), 32'd1);
        check(req_valid === 1'b0, "R5 novalid", 32'(req_valid), 32'd0);
        check(err === hz, "R9 err", 32'(err), 32'(hz));
        check(wb_en === (wb && !hz), "R6 wb_en", 32'(wb_en), 32'(wb && !hz));
        if (wb && !hz) check(wb_value === fin, "R6 wb_value", wb_value, fin);
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, inject ? "R8 idle" : "R5 idle", {busy, done}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [15:0] masks [0:23];
        logic [31:0] base;
        int t;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && req_valid === 1'b0 && done === 1'b0 && wb_en === 1'b0 && err === 1'b0,
              "R11 reset", {busy, req_valid, done, wb_en, err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && req_valid === 1'b0, "R11 idle", {busy, req_valid}, 32'd0);
        masks[0] = 16'h0000; masks[1] = 16'h0001; masks[2] = 16'h8000; masks[3] = 16'hFFFF;
        masks[4] = 16'h00F0; masks[5] = 16'h5555; masks[6] = 16'hAAAA; masks[7] = 16'h8001;
        lfsr = 16'hACE1;
        for (int k = 8; k < 24; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            masks[k] = lfsr;
        end
        t = 0;
        for (int md = 0; md < 4; md++)
            for (int ld = 0; ld < 2; ld++)
                for (int wb = 0; wb < 2; wb++)
                    for (int k = 0; k < 24; k++) begin
                        base = (t % 5 == 0) ? 32'h0000_0008 : 32'h2000_0000 + 32'(t * 64);
                        run(2'(md), masks[k], ld[0], wb[0], base, 4'(t % 16), (t % 7 == 3) && masks[k] != 0);
                        t++;
                    end
        // push and pop pair
        run(2'd3, 16'h00F0, 1'b0, 1'b1, 32'h0000_1000, 4'd13, 1'b0);
        run(2'd0, 16'h00F0, 1'b1, 1'b1, 32'h0000_0FF0, 4'd13, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule